// File: doc/BRIEF.md
# Rational-Ratio Waveform Table Player

This block plays back a waveform held in a writable sample RAM. Software or a setup engine first loads one or more complete cycles of the waveform through a plain write port while playback is stopped. When the run enable is raised, a read index starts at entry zero and moves forward by exactly one entry on every enabled clock. After the last active entry it returns to zero. The number of active entries, L, is programmable.

The index never steps by a fractional tuning word, so no phase bits are thrown away. The output sequence repeats exactly every L clocks. If the table holds C complete cycles, the output frequency is C / L times the clock frequency. That ratio is always exactly rational, and playback has no truncation spur and no rollover glitch.

A small two-state controller, IDLE and RUN, governs playback. The START transition goes from IDLE to RUN when run_en is sampled high. The STOP transition goes from RUN to IDLE when run_en is sampled low. In IDLE the index rests at zero and the active length tracks the length input. In RUN the index steps forward, and a new length is adopted only at a cycle boundary.

Top module: `wave_table_player`

## Requirements
- R1: A write with wr_en high while run_en is low stores wr_data at wr_addr. A later playback of that entry outputs the new value.
- R2: A write attempted while run_en is high is ignored. The RAM contents are unchanged, as seen in every later playback.
- R3: On the first rising edge at which run_en is sampled high, sample_out takes entry 0. Each following enabled edge moves to the next entry, one entry per clock.
- R4: With an effective length L of at least 2, the entry after L-1 is entry 0. The output sequence repeats exactly every L clocks.
- R5: wrap_pulse is high for exactly one clock, in the same cycle that sample_out shows entry 0 after entry L-1. It is not raised for the first entry after a start.
- R6: An effective length of 0 or 1 keeps sample_out at entry 0 and never raises wrap_pulse.
- R7: sample_valid equals run_en as sampled at the previous rising edge. It rises one clock after run_en rises and falls one clock after run_en falls.
- R8: A change of len_cfg during playback takes effect only when the index next returns to zero. The current cycle finishes at the old length.
- R9: A len_cfg value larger than the table depth, 2**ADDR_W, is treated as the table depth.
- R10: After reset, sample_out, sample_valid and wrap_pulse are all zero.
- R11: After a STOP, the next START begins again at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_addr | input | ADDR_W | Table entry to write |
| wr_data | input | DATA_W | Sample value to write |
| wr_en | input | 1 | Write strobe, honoured only while run_en is low |
| len_cfg | input | ADDR_W+1 | Number of active entries L |
| run_en | input | 1 | Playback enable |
| sample_out | output | DATA_W | Current sample |
| wrap_pulse | output | 1 | One-clock strobe when playback returns to entry 0 |
| sample_valid | output | 1 | sample_out carries a playback sample |

## Verification
The bound checker enforces several properties on every cycle:
- sample_valid is run_en delayed by one clock.
- wrap_pulse never lasts two clocks and never appears without sample_valid.
- The internal index grows by exactly one between consecutive running cycles unless it has returned to zero.
- The index stays below the active length.
- The index is pinned at zero under a length of 0 or 1.

Only the bench scenarios can show what the stored data looks like at the output. That includes a sequence that repeats every L clocks, writes that are ignored while running, a length change that waits for the wrap, clamping of oversize lengths, and a restart from entry zero.

// File: rtl/wtp_pkg.sv
package wtp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wtp_state_e;
endpackage

// File: rtl/wtp_sample_ram.sv
module wtp_sample_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // one-cycle registered read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/wtp_index_seq.sv
module wtp_index_seq
    import wtp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ADDR_W:0]   len_cfg,
    output logic [ADDR_W-1:0] idx,
    output logic              wrap_hit,
    output logic [ADDR_W:0]   act_len,
    output wtp_state_e        state
);
    localparam int          LEN_W = ADDR_W + 1;
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(1 << ADDR_W);

    wtp_state_e       state_nx;
    logic [LEN_W-1:0] len_clamped;
    logic [LEN_W-1:0] eff_len;
    logic             at_last;
    logic             short_len;

    assign len_clamped = (len_cfg > DEPTH_L) ? DEPTH_L : len_cfg;
    assign eff_len     = (state == ST_IDLE) ? len_clamped : act_len;
    assign short_len   = (eff_len <= LEN_W'(1));
    assign at_last     = ({1'b0, idx} == (eff_len - LEN_W'(1)));

    // next-state logic: START and STOP transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (run_en)  state_nx = ST_RUN;
            ST_RUN:  if (!run_en) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // index, active length and wrap flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            wrap_hit <= 1'b0;
            act_len  <= '0;
        end else if (!run_en) begin
            idx      <= '0;
            wrap_hit <= 1'b0;
            act_len  <= len_clamped;
        end else if (short_len) begin
            idx      <= '0;
            wrap_hit <= 1'b0;
            act_len  <= len_clamped;
        end else if (at_last) begin
            idx      <= '0;
            wrap_hit <= 1'b1;
            act_len  <= len_clamped;
        end else begin
            idx      <= idx + ADDR_W'(1);
            wrap_hit <= 1'b0;
            act_len  <= eff_len;
        end
    end
endmodule

// File: rtl/wave_table_player.sv
module wave_table_player
    import wtp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   len_cfg,
    input  logic              run_en,
    output logic [DATA_W-1:0] sample_out,
    output logic              wrap_pulse,
    output logic              sample_valid
);
    logic [ADDR_W-1:0] seq_idx;
    logic              seq_wrap;
    logic [ADDR_W:0]   seq_act_len;
    wtp_state_e        seq_state;
    logic              ram_we;

    assign ram_we = wr_en & ~run_en;

    wtp_index_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .len_cfg  (len_cfg),
        .idx      (seq_idx),
        .wrap_hit (seq_wrap),
        .act_len  (seq_act_len),
        .state    (seq_state)
    );

    wtp_sample_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (run_en),
        .raddr (seq_idx),
        .rdata (sample_out)
    );

    // output flags aligned with the registered RAM read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            wrap_pulse   <= 1'b0;
        end else begin
            sample_valid <= run_en;
            wrap_pulse   <= run_en & seq_wrap;
        end
    end
endmodule

// File: rtl/wtp_checker.sv
module wtp_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              sample_valid,
    input logic              wrap_pulse,
    input logic [ADDR_W-1:0] idx,
    input logic [ADDR_W:0]   act_len,
    input logic              state
);
    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> sample_valid);

    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sample_valid);

    assert_wrap_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    assert_wrap_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> sample_valid);

    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && idx != '0) |-> idx == $past(idx) + ADDR_W'(1));

    assert_idx_below_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state && act_len > (ADDR_W+1)'(1)) |-> ({1'b0, idx} < act_len));

    assert_short_len_pinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state && act_len <= (ADDR_W+1)'(1)) |-> idx == '0);
endmodule

bind wave_table_player wtp_checker #(.ADDR_W(ADDR_W)) u_wtp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .sample_valid (sample_valid),
    .wrap_pulse   (wrap_pulse),
    .idx          (seq_idx),
    .act_len      (seq_act_len),
    .state        (seq_state)
);

// File: tb/wave_table_player_bench.sv
module wave_table_player_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 5;
    // vector table: requested length and number of cycles to observe
    localparam int VEC_LEN [NVEC] = '{5, 2, 64, 7, 100};
    localparam int VEC_CYC [NVEC] = '{12, 6, 70, 15, 70};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W:0]   len_cfg = '0;
    logic              run_en = 1'b0;
    logic [DATA_W-1:0] sample_out;
    logic              wrap_pulse;
    logic              sample_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_table_player #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wave_table_player (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_en        (wr_en),
        .len_cfg      (len_cfg),
        .run_en       (run_en),
        .sample_out   (sample_out),
        .wrap_pulse   (wrap_pulse),
        .sample_valid (sample_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_entry(input int a, input int d);
        wr_addr = ADDR_W'(a);
        wr_data = DATA_W'(d);
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
        if (!run_en) model[a] = DATA_W'(d);
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        tick();
        chk("R7 valid low after stop", int'(sample_valid), 0);
    endtask

    // play with fixed effective length, check n samples starting at entry 0
    task automatic play(input int len, input int cycles, input string tag);
        int eff;
        eff = (len > DEPTH) ? DEPTH : len;
        len_cfg = (ADDR_W+1)'(len);
        run_en  = 1'b1;
        for (int n = 0; n < cycles; n++) begin
            int e;
            tick();
            e = (eff <= 1) ? 0 : (n % eff);
            chk({tag, " sample"}, int'(sample_out), int'(model[e]));
            chk("R7 valid while running", int'(sample_valid), 1);
            chk({tag, " R5 wrap"}, int'(wrap_pulse),
                (eff > 1 && n > 0 && (n % eff) == 0) ? 1 : 0);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) tick();
        // R10 reset state
        chk("R10 sample_out", int'(sample_out), 0);
        chk("R10 valid", int'(sample_valid), 0);
        chk("R10 wrap", int'(wrap_pulse), 0);
        rst_n = 1'b1;
        tick();
        chk("R10 valid after release", int'(sample_valid), 0);

        // R1 load the table while idle
        for (int i = 0; i < DEPTH; i++) write_entry(i, (i * 37 + 5) & 12'hFFF);

        // table walk: R3 R4 R5 R9 R11 (each restarts at entry 0)
        for (int v = 0; v < NVEC; v++) begin
            play(VEC_LEN[v], VEC_CYC[v], "R3 R4 R9 R11 table");
            stop_run();
        end

        // R2 write while running is ignored
        len_cfg = 7'd5;
        run_en  = 1'b1;
        tick();
        wr_addr = 6'd3;
        wr_data = 12'hABC;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
        stop_run();
        play(5, 10, "R2 after blocked write");
        stop_run();

        // R1 idle write becomes visible
        write_entry(3, 12'h5A5);
        play(5, 6, "R1 idle write");
        chk("R1 entry 3", int'(model[3]), 12'h5A5);
        stop_run();

        // R6 lengths 0 and 1
        play(0, 6, "R6 len0");
        stop_run();
        play(1, 6, "R6 len1");
        stop_run();

        // R8 length change mid-run: 4 then 6
        len_cfg = 7'd4;
        run_en  = 1'b1;
        for (int n = 0; n < 12; n++) begin
            int e;
            int w;
            tick();
            if (n == 1) len_cfg = 7'd6;
            e = (n < 4) ? n : (n - 4) % 6;
            w = (n == 4 || n == 10) ? 1 : 0;
            chk("R8 sample", int'(sample_out), int'(model[e]));
            chk("R8 wrap", int'(wrap_pulse), w);
        end
        stop_run();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule